// File: doc/BRIEF.md
# Privilege-Aware Virtual Address Segment Mapper

This block sits between a processor's address generation and its memory system. It holds the current privilege level, user or kernel, and sorts each 32-bit virtual address into a segment. For that segment it reports one of three outcomes: the reference needs a translation lookaside buffer lookup, it can go straight to a physical address, or it is illegal at the current privilege. It also reports whether the reference may be cached. When the reference needs a TLB lookup, the block supplies the lookup tag, which is the 6-bit process identifier joined to the virtual page number.

The privilege level is user out of reset. An exception-entry pulse raises it to kernel and saves the old level in a previous-level bit. A return-from-exception pulse brings the saved level back. The address decode is purely combinational from the current level and the address, so its results follow the address in the same cycle.

The decode depends on whether a TLB is present, which is set by the `tlb_on` input. Two kernel windows of 512 MB each map onto the same lowest 512 MB of physical space. One window is cached and the other is not.

Top module: `vaseg_mapper`

## Requirements
- R1: After reset the block is in user mode, so a reference with address bit 31 set raises `addr_err`.
- R2: An `exc_enter` pulse puts the block in kernel mode from the next clock edge. Kernel mode then holds until a return pulse arrives.
- R3: On `exc_enter` the current mode is saved as the previous mode. On `exc_return` without `exc_enter` the current mode is restored from the saved one. When both pulses arrive in the same cycle, entry wins.
- R4: When `tlb_on`=1, an address in 0x0000_0000–0x7FFF_FFFF sets `need_tlb`=1 in either mode, with `ext_tag` = {pid[5:0], vaddr[31:12]}. While `need_tlb`=1, `paddr` and `cacheable` are 0.
- R5: When `tlb_on`=0, an address in 0x0000_0000–0x7FFF_FFFF gives `paddr` = vaddr + 0x4000_0000 and `cacheable`=1, in either mode.
- R6: In user mode, any address at 0x8000_0000 or above sets `addr_err`=1. For that reference `need_tlb`, `cacheable`, `paddr` and `ext_tag` are all 0.
- R7: In kernel mode, addresses 0x8000_0000–0x9FFF_FFFF give `paddr` = vaddr − 0x8000_0000 with `cacheable`=1 and `need_tlb`=0, whatever the value of `tlb_on`.
- R8: In kernel mode, addresses 0xA000_0000–0xBFFF_FFFF give `paddr` = vaddr − 0xA000_0000 with `cacheable`=0 and `need_tlb`=0, whatever the value of `tlb_on`.
- R9: In kernel mode, for addresses 0xC000_0000–0xFFFF_FFFF: with `tlb_on`=1 the result is a TLB reference as in R4. With `tlb_on`=0 the result is `paddr` = vaddr and `cacheable`=1.
- R10: The decode outputs follow `vaddr` within the same cycle. A mode change becomes visible only after the clock edge that samples the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; sets user mode |
| vaddr | input | 32 | Virtual address of the reference |
| tlb_on | input | 1 | 1 when a TLB is present and used |
| exc_enter | input | 1 | One-cycle exception-entry pulse |
| exc_return | input | 1 | One-cycle return-from-exception pulse |
| pid | input | 6 | Current process identifier |
| paddr | output | 32 | Physical address; 0 when the reference needs the TLB or is illegal |
| need_tlb | output | 1 | Reference must be translated by the TLB |
| ext_tag | output | 26 | TLB lookup tag: {pid, virtual page}; 0 when `need_tlb` is 0 |
| cacheable | output | 1 | Reference may use the cache |
| addr_err | output | 1 | Illegal reference for the current mode |

## Verification
Every decode result depends only on the current mode and the inputs, so it is due in the same cycle as the stimulus. The bench applies an address after the falling edge and samples 2 ns later, well before the next rising edge. A mode pulse takes effect one edge later. The bench samples one address while the pulse is still pending, which must still decode under the old mode, and samples again after the edge to see the new mode. The scoreboard's mode model advances on that same edge, so every expected value refers to the mode the design should hold at the moment of sampling.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

  localparam int unsigned VA_W = 32;

  typedef enum logic [2:0] {
    SEG_LOW      = 3'd0,
    SEG_CACHED   = 3'd1,
    SEG_UNCACHED = 3'd2,
    SEG_HIGH     = 3'd3,
    SEG_BAD      = 3'd4
  } seg_e;

  // Segment selection from the top address bits and privilege level
  function automatic seg_e classify(input logic kern, input logic [VA_W-1:0] va);
    if (!va[VA_W-1]) return SEG_LOW;
    if (!kern) return SEG_BAD;
    case (va[VA_W-2:VA_W-3])
      2'b00:   return SEG_CACHED;
      2'b01:   return SEG_UNCACHED;
      default: return SEG_HIGH;
    endcase
  endfunction

  // Lower segment without a TLB: fixed offset into physical space
  function automatic logic [VA_W-1:0] low_direct(input logic [VA_W-1:0] va,
                                                 input logic [VA_W-1:0] off);
    return va + off;
  endfunction

  // Kernel direct windows: strip the window-select bits
  function automatic logic [VA_W-1:0] window_strip(input logic [VA_W-1:0] va);
    logic [VA_W-1:0] m;
    m = {3'b000, {(VA_W-3){1'b1}}};
    return va & m;
  endfunction

endpackage

// File: rtl/vaseg_mode.sv
module vaseg_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic exc_enter,
  input  logic exc_return,
  output logic kernel
);
  logic kernel_q;
  logic prev_q;
  logic enter_w;
  logic leave_w;

  assign enter_w = exc_enter;
  assign leave_w = exc_return && !exc_enter;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kernel_q <= 1'b0;
      prev_q   <= 1'b0;
    end else if (enter_w) begin
      prev_q   <= kernel_q;
      kernel_q <= 1'b1;
    end else if (leave_w) begin
      kernel_q <= prev_q;
    end
  end

  assign kernel = kernel_q;

  assert_enter_kernel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> kernel_q);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!exc_enter && !exc_return) |=> $stable(kernel_q));

  assert_enter_save_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_enter |=> (prev_q == $past(kernel_q)));

  assert_return_restore_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter) |=> (kernel_q == $past(prev_q)));

endmodule

// File: rtl/vaseg_decode.sv
module vaseg_decode
  import vaseg_pkg::*;
#(
  parameter int unsigned PID_W      = 6,
  parameter int unsigned PAGE_W     = 12,
  parameter logic [31:0] LOW_OFFSET = 32'h4000_0000,
  localparam int unsigned VPN_W     = VA_W - PAGE_W,
  localparam int unsigned TAG_W     = PID_W + VPN_W
) (
  input  logic             kernel,
  input  logic             tlb_on,
  input  logic [VA_W-1:0]  vaddr,
  input  logic [PID_W-1:0] pid,
  output seg_e             seg,
  output logic [VA_W-1:0]  paddr,
  output logic             need_tlb,
  output logic [TAG_W-1:0] ext_tag,
  output logic             cacheable,
  output logic             addr_err
);
  logic [TAG_W-1:0] tag_w;
  assign tag_w = {pid, vaddr[VA_W-1:PAGE_W]};

  always_comb begin
    seg       = classify(kernel, vaddr);
    paddr     = '0;
    need_tlb  = 1'b0;
    ext_tag   = '0;
    cacheable = 1'b0;
    addr_err  = 1'b0;
    case (seg)
      SEG_LOW: begin
        if (tlb_on) begin
          need_tlb = 1'b1;
          ext_tag  = tag_w;
        end else begin
          paddr     = low_direct(vaddr, LOW_OFFSET);
          cacheable = 1'b1;
        end
      end
      SEG_CACHED: begin
        paddr     = window_strip(vaddr);
        cacheable = 1'b1;
      end
      SEG_UNCACHED: begin
        paddr = window_strip(vaddr);
      end
      SEG_HIGH: begin
        if (tlb_on) begin
          need_tlb = 1'b1;
          ext_tag  = tag_w;
        end else begin
          paddr     = vaddr;
          cacheable = 1'b1;
        end
      end
      default: begin
        addr_err = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/vaseg_mapper.sv
module vaseg_mapper
  import vaseg_pkg::*;
#(
  parameter int unsigned PID_W      = 6,
  parameter int unsigned PAGE_W     = 12,
  parameter logic [31:0] LOW_OFFSET = 32'h4000_0000,
  localparam int unsigned TAG_W     = PID_W + VA_W - PAGE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VA_W-1:0]  vaddr,
  input  logic             tlb_on,
  input  logic             exc_enter,
  input  logic             exc_return,
  input  logic [PID_W-1:0] pid,
  output logic [VA_W-1:0]  paddr,
  output logic             need_tlb,
  output logic [TAG_W-1:0] ext_tag,
  output logic             cacheable,
  output logic             addr_err
);
  logic kern_w;
  seg_e seg_w;

  vaseg_mode u_mode (
    .clk        (clk),
    .rst_n      (rst_n),
    .exc_enter  (exc_enter),
    .exc_return (exc_return),
    .kernel     (kern_w)
  );

  vaseg_decode #(
    .PID_W      (PID_W),
    .PAGE_W     (PAGE_W),
    .LOW_OFFSET (LOW_OFFSET)
  ) u_dec (
    .kernel    (kern_w),
    .tlb_on    (tlb_on),
    .vaddr     (vaddr),
    .pid       (pid),
    .seg       (seg_w),
    .paddr     (paddr),
    .need_tlb  (need_tlb),
    .ext_tag   (ext_tag),
    .cacheable (cacheable),
    .addr_err  (addr_err)
  );

  assert_user_upper_err_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!kern_w && vaddr[VA_W-1]) |-> (addr_err && !need_tlb && !cacheable && paddr == '0));

  assert_tlb_pa_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    need_tlb |-> (paddr == '0 && !cacheable && !addr_err));

  assert_cached_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_w == SEG_CACHED) |-> (cacheable && !need_tlb && paddr[VA_W-1:VA_W-3] == 3'b000));

  assert_uncached_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_w == SEG_UNCACHED) |-> (!cacheable && !need_tlb && paddr[VA_W-1:VA_W-3] == 3'b000));

  assert_kernel_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kern_w |-> !addr_err);

  assert_outcome_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({need_tlb, addr_err}));

endmodule

// File: tb/vaseg_mapper_test.sv
module vaseg_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] vaddr = '0;
  logic        tlb_on = 1'b0;
  logic        exc_enter = 1'b0;
  logic        exc_return = 1'b0;
  logic [5:0]  pid = '0;
  logic [31:0] paddr;
  logic        need_tlb;
  logic [25:0] ext_tag;
  logic        cacheable;
  logic        addr_err;

  always #5 clk = ~clk;

  vaseg_mapper uut (
    .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .tlb_on(tlb_on),
    .exc_enter(exc_enter), .exc_return(exc_return), .pid(pid),
    .paddr(paddr), .need_tlb(need_tlb), .ext_tag(ext_tag),
    .cacheable(cacheable), .addr_err(addr_err)
  );

  typedef struct {
    string       req;
    logic [31:0] pa;
    logic        tl;
    logic [25:0] tg;
    logic        ca;
    logic        er;
  } exp_t;

  exp_t q[$];
  int vectors = 0;
  int miscompares = 0;
  bit m_kern = 1'b0;
  bit m_prev = 1'b0;
  event sample_ev;

  function automatic exp_t model(string req, bit kern, logic [31:0] va, bit tl, logic [5:0] p);
    exp_t e;
    e.req = req; e.pa = 32'h0; e.tl = 1'b0; e.tg = 26'h0; e.ca = 1'b0; e.er = 1'b0;
    if (va < 32'h8000_0000) begin
      if (tl) begin e.tl = 1'b1; e.tg = 26'((32'(p) << 20) | (va >> 12)); end
      else begin e.pa = va + 32'h4000_0000; e.ca = 1'b1; end
    end else if (!kern) begin
      e.er = 1'b1;
    end else if (va < 32'hA000_0000) begin
      e.pa = va - 32'h8000_0000; e.ca = 1'b1;
    end else if (va < 32'hC000_0000) begin
      e.pa = va - 32'hA000_0000;
    end else if (tl) begin
      e.tl = 1'b1; e.tg = 26'((32'(p) << 20) | (va >> 12));
    end else begin
      e.pa = va; e.ca = 1'b1;
    end
    return e;
  endfunction

  // Driver: set inputs, queue the expectation, hand off to the monitor
  task automatic apply(string req, logic [31:0] va, bit tl, logic [5:0] p);
    q.push_back(model(req, m_kern, va, tl, p));
    vaddr = va; tlb_on = tl; pid = p;
    #2;
    -> sample_ev;
    #0;
  endtask

  // Monitor: compare outputs against the queued expectation
  initial begin
    forever begin
      @(sample_ev);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        vectors++;
        if (paddr !== e.pa || need_tlb !== e.tl || ext_tag !== e.tg ||
            cacheable !== e.ca || addr_err !== e.er) begin
          miscompares++;
          $display("FAIL %s: got pa=%h tlb=%b tag=%h ca=%b err=%b exp pa=%h tlb=%b tag=%h ca=%b err=%b",
                   e.req, paddr, need_tlb, ext_tag, cacheable, addr_err,
                   e.pa, e.tl, e.tg, e.ca, e.er);
        end
      end
    end
  end

  // Pulse task: checks old mode still decodes before the edge (R10)
  task automatic pulse(bit en, bit rt);
    @(negedge clk);
    exc_enter = en; exc_return = rt;
    apply("R10 pre-edge mode", 32'h8000_0000, 1'b0, 6'd0);
    @(posedge clk);
    if (en) begin m_prev = m_kern; m_kern = 1'b1; end
    else if (rt) m_kern = m_prev;
    @(negedge clk);
    exc_enter = 1'b0; exc_return = 1'b0;
  endtask

  bit done = 1'b0;
  initial begin
    #1_000_000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung exp finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state is user
    apply("R1 reset user upper", 32'h9000_0000, 1'b0, 6'd0);
    apply("R5 user low direct", 32'h1234_5678, 1'b0, 6'd0);
    apply("R5 user low top edge", 32'h7FFF_FFFF, 1'b0, 6'd0);
    apply("R4 user low tlb", 32'h0040_1ABC, 1'b1, 6'd5);
    apply("R6 user top addr", 32'hFFFF_FFFF, 1'b1, 6'd9);
    apply("R6 user high tlb", 32'hC000_0000, 1'b1, 6'd9);
    // R10 same-cycle follow
    @(negedge clk);
    apply("R10 follow a", 32'h0000_0000, 1'b0, 6'd0);
    apply("R10 follow b", 32'h8000_0000, 1'b0, 6'd0);
    // R2 enter kernel
    pulse(1'b1, 1'b0);
    apply("R2 kernel cached base", 32'h8000_0000, 1'b0, 6'd0);
    apply("R7 cached top tlb on", 32'h9FFF_FFFF, 1'b1, 6'd1);
    apply("R8 uncached", 32'hA000_0010, 1'b0, 6'd0);
    apply("R8 uncached top tlb on", 32'hBFFF_FFFF, 1'b1, 6'd2);
    apply("R9 high direct", 32'hC000_1000, 1'b0, 6'd0);
    apply("R9 high tlb", 32'hFEDC_B123, 1'b1, 6'd63);
    apply("R4 kernel low tlb", 32'h7FFF_F000, 1'b1, 6'd33);
    apply("R5 kernel low direct", 32'h0000_0000, 1'b0, 6'd0);
    repeat (3) @(negedge clk);
    apply("R2 kernel persists", 32'hA000_0000, 1'b0, 6'd0);
    // R3 return restores user
    pulse(1'b0, 1'b1);
    apply("R3 return to user", 32'h8000_0004, 1'b0, 6'd0);
    // R3 both pulses: entry wins
    pulse(1'b1, 1'b1);
    apply("R3 entry wins", 32'h8000_0004, 1'b0, 6'd0);
    // nested entry saves kernel, return keeps kernel
    pulse(1'b1, 1'b0);
    pulse(1'b0, 1'b1);
    apply("R3 nested return", 32'hA123_4567, 1'b0, 6'd0);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule